// File: doc/BRIEF.md
# Two-Wire Slave with Lockable User Memory

This block is a slave on a two-wire serial bus (I2C-style). It serves a small byte-wide user memory of `MEM_BYTES` locations, 10 by default. The bus lines are oversampled on the system clock. The block drives the data line only through an open-drain style enable: when `sda_oe_o` is high, the pad pulls SDA low. A host selects the block with a 7-bit address and a direction bit. On a write, the host sends a location pointer and then any number of data bytes. On a read, the host receives bytes starting at the current pointer. The pointer advances by one after every data byte.

Location `MEM_BYTES` (10 by default) holds a write-lock flag. Once the flag is set, the user locations no longer accept writes until reset. Written bytes first land in a shadow copy. They move to the backing copy, which reads return, only while the external event input is inactive. Writes made while the event is active therefore become visible when the event drops.

Top module: `tw_user_mem_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), every user location reads 00h and the lock location reads 00h.
- R2: The first byte after a START is acknowledged only when its bits 7:1 equal `DEV_ADDR`; bit 0 selects the direction (1 = read, 0 = write). On a mismatch, no byte is acknowledged and no byte is stored until the next START.
- R3: In a write, the byte after the address loads the pointer. Every later data byte is acknowledged and stored at the pointer, which then advances.
- R4: A read returns bytes MSB first, starting at the pointer, which advances after each byte. The lock location returns the flag in bit 0 with the other bits 0. For reads and writes alike, the pointer moves from the lock location to location 0.
- R5: When the host does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START.
- R6: The contents returned by reads change only while the synchronised event input is inactive. A write made while the event is active becomes readable a few cycles after the event drops.
- R7: Writing the lock location with bit 0 = 1 sets the lock. From then on, writes to user locations are still acknowledged but leave the contents unchanged. Only reset clears the lock.
- R8: When the pointer is above the lock location, a written byte is acknowledged and discarded, a read returns FFh, and the pointer then moves to location 0.
- R9: A repeated START in place of a STOP begins a new address phase, in either direction.
- R10: A START or a STOP releases SDA on the next cycle. The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| event_i | input | 1 | Event input; while high, writes are held in the shadow copy |

## Verification
Most internal faults show up at the bus within one byte time. A wrong bit or state counter moves or drops the acknowledge on the ninth clock of the same byte. A wrong pointer shows as a misplaced byte on the next read-back. A wrong commit or lock path only appears when the affected location is read. The bench therefore reads back after every write burst, and after each event change or lock change. Reads are placed so that a stale or unlocked byte is visible within one transaction.

// File: rtl/tw_um_pkg.sv
package tw_um_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WDAT,
      ST_ACK,
      ST_TX,
      ST_MACK
   } tw_state_e;

   // location after 'loc'; anything at or past 'last' goes back to zero
   function automatic logic [7:0] tw_next_loc(input logic [7:0] loc, input logic [7:0] last);
      return (loc >= last) ? 8'd0 : loc + 8'd1;
   endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int             WIDTH  = 1,
   parameter int             STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_line_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tw_line_sync: WIDTH must be at least 1");
      end
   endgenerate

   // stage STAGES-1 is the synchronised value, stage STAGES its previous sample
   logic [STAGES:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {(STAGES+1){IDLE}};
      else        stg <= {stg[STAGES-1:0], d};
   end

   assign q      = stg[STAGES-1];
   assign q_prev = stg[STAGES];

endmodule

// File: rtl/tw_bus_engine.sv
module tw_bus_engine
   import tw_um_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h52,
   parameter int         LAST_LOC = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_q,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_p,
   input  logic       stop_p,
   input  logic [7:0] rd_data,
   output logic [7:0] ptr,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data
);

   localparam logic [7:0] LAST = 8'(LAST_LOC);

   tw_state_e  st_q, after_q;
   logic [3:0] cnt_q;
   logic [7:0] sh_q;
   logic [7:0] tx_q;
   logic       mack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         after_q <= ST_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         tx_q    <= '0;
         mack_q  <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_p) begin
            st_q   <= ST_ADDR;
            cnt_q  <= '0;
            sda_oe <= 1'b0;
         end else if (stop_p) begin
            st_q   <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADDR, ST_PTR, ST_WDAT: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[6:0], sda_q};
                     cnt_q <= cnt_q + 4'd1;
                  end else if (scl_fall && cnt_q == 4'd8) begin
                     cnt_q <= '0;
                     if (st_q == ST_ADDR) begin
                        if (sh_q[7:1] == DEV_ADDR) begin
                           sda_oe  <= 1'b1;
                           st_q    <= ST_ACK;
                           after_q <= sh_q[0] ? ST_TX : ST_PTR;
                        end else begin
                           st_q <= ST_IDLE;
                        end
                     end else if (st_q == ST_PTR) begin
                        sda_oe  <= 1'b1;
                        st_q    <= ST_ACK;
                        after_q <= ST_WDAT;
                        ptr     <= sh_q;
                     end else begin
                        sda_oe  <= 1'b1;
                        st_q    <= ST_ACK;
                        after_q <= ST_WDAT;
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= sh_q;
                        ptr     <= tw_next_loc(ptr, LAST);
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     st_q  <= after_q;
                     cnt_q <= '0;
                     if (after_q == ST_TX) begin
                        tx_q   <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= tw_next_loc(ptr, LAST);
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt_q <= cnt_q + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt_q == 4'd8) begin
                        sda_oe <= 1'b0;
                        st_q   <= ST_MACK;
                     end else begin
                        tx_q   <= {tx_q[6:0], 1'b0};
                        sda_oe <= ~tx_q[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_q;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_q   <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= tw_next_loc(ptr, LAST);
                        cnt_q  <= '0;
                        st_q   <= ST_TX;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/tw_user_store.sv
module tw_user_store #(
   parameter int MEM_BYTES = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [7:0]             wr_addr,
   input  logic [7:0]             wr_data,
   input  logic [7:0]             rd_addr,
   input  logic                   evt_q,
   input  logic                   evt_prev,
   output logic [7:0]             rd_data,
   output logic                   lock_q,
   output logic [MEM_BYTES*8-1:0] shadow_flat,
   output logic [MEM_BYTES*8-1:0] backing_flat
);

   localparam logic [7:0] LOCK_LOC = 8'(MEM_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_flat <= '0;
      end else begin
         for (int i = 0; i < MEM_BYTES; i++) begin
            if (wr_en && !lock_q && wr_addr == 8'(i)) shadow_flat[i*8 +: 8] <= wr_data;
         end
      end
   end

   // commit only once the event has read inactive on two samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 backing_flat <= '0;
      else if (!evt_q && !evt_prev) backing_flat <= shadow_flat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      lock_q <= 1'b0;
      else if (wr_en && wr_addr == LOCK_LOC && wr_data[0]) lock_q <= 1'b1;
   end

   always_comb begin
      rd_data = 8'hFF;
      if (rd_addr == LOCK_LOC) rd_data = {7'd0, lock_q};
      for (int k = 0; k < MEM_BYTES; k++) begin
         if (rd_addr == 8'(k)) rd_data = backing_flat[k*8 +: 8];
      end
   end

endmodule

// File: rtl/tw_user_mem_slave.sv
module tw_user_mem_slave
   import tw_um_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h52,
   parameter int         MEM_BYTES   = 10,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o,
   input  logic event_i
);

   localparam int         LINES     = 3;
   localparam logic [2:0] LINE_IDLE = 3'b011;
   localparam int         MW        = MEM_BYTES * 8;

   generate
      if (MEM_BYTES < 1 || MEM_BYTES > 254) begin : g_bad_depth
         $error("tw_user_mem_slave: MEM_BYTES must be within 1..254");
      end
   endgenerate

   logic [LINES-1:0] ln_q, ln_prev;

   tw_line_sync #(
      .WIDTH (LINES),
      .STAGES(SYNC_STAGES),
      .IDLE  (LINE_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({event_i, sda_i, scl_i}),
      .q     (ln_q),
      .q_prev(ln_prev)
   );

   logic scl_s, sda_s, evt_s, evt_prev;
   logic scl_rise, scl_fall, start_p, stop_p;

   assign scl_s    = ln_q[0];
   assign sda_s    = ln_q[1];
   assign evt_s    = ln_q[2];
   assign evt_prev = ln_prev[2];
   assign scl_rise = scl_s & ~ln_prev[0];
   assign scl_fall = ~scl_s & ln_prev[0];
   assign start_p  = scl_s & ln_prev[0] & ~sda_s & ln_prev[1];
   assign stop_p   = scl_s & ln_prev[0] & sda_s & ~ln_prev[1];

   logic [7:0]    ptr, rd_data, wr_addr, wr_data;
   logic          wr_en, lock_q;
   logic [MW-1:0] shadow_flat, backing_flat;

   tw_bus_engine #(
      .DEV_ADDR(DEV_ADDR),
      .LAST_LOC(MEM_BYTES)
   ) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .sda_q   (sda_s),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_p (start_p),
      .stop_p  (stop_p),
      .rd_data (rd_data),
      .ptr     (ptr),
      .sda_oe  (sda_oe_o),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   tw_user_store #(
      .MEM_BYTES(MEM_BYTES)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rd_addr     (ptr),
      .evt_q       (evt_s),
      .evt_prev    (evt_prev),
      .rd_data     (rd_data),
      .lock_q      (lock_q),
      .shadow_flat (shadow_flat),
      .backing_flat(backing_flat)
   );

endmodule

// File: rtl/tw_user_mem_slave_chk.sv
module tw_user_mem_slave_chk #(
   parameter int MEM_BYTES = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   scl_s,
   input logic                   start_p,
   input logic                   stop_p,
   input logic                   sda_oe_o,
   input logic                   evt_s,
   input logic                   lock_q,
   input logic [MEM_BYTES*8-1:0] shadow_flat,
   input logic [MEM_BYTES*8-1:0] backing_flat
);

   a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !sda_oe_o);

   a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe_o);

   a_r10_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);

   a_r6_hold_while_event: assert property (@(posedge clk) disable iff (!rst_n)
      evt_s |=> $stable(backing_flat));

   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   a_r7_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(shadow_flat));

endmodule

bind tw_user_mem_slave tw_user_mem_slave_chk #(
   .MEM_BYTES(MEM_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_s       (scl_s),
   .start_p     (start_p),
   .stop_p      (stop_p),
   .sda_oe_o    (sda_oe_o),
   .evt_s       (evt_s),
   .lock_q      (lock_q),
   .shadow_flat (shadow_flat),
   .backing_flat(backing_flat)
);

// File: tb/tw_user_mem_slave_bench.sv
module tw_user_mem_slave_bench;

   localparam int         Q   = 6;
   localparam int         N   = 10;
   localparam logic [6:0] DEV = 7'h52;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, evt = 1'b0;
   logic sda_oe, sda_line;

   assign sda_line = sda_m & ~sda_oe;

   always #5 clk = ~clk;

   tw_user_mem_slave #(.DEV_ADDR(DEV), .MEM_BYTES(N)) u_tw_user_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .event_i(evt));

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_sh [N];
   logic [7:0] m_bk [N];
   logic       m_lock = 1'b0;
   logic [7:0] wbuf [8];
   logic [7:0] rbuf [16];

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] nxt(input logic [7:0] p);
      return (p >= 8'(N)) ? 8'd0 : p + 8'd1;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [7:0] p);
      if (p < 8'(N))  return m_bk[int'(p)];
      if (p == 8'(N)) return {7'd0, m_lock};
      return 8'hFF;
   endfunction

   task automatic commit_model();
      if (!evt) for (int i = 0; i < N; i++) m_bk[i] = m_sh[i];
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(Q);
      sda_m = 1'b0; wclk(Q); scl = 1'b0; wclk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wclk(Q); scl = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b; wclk(Q); scl = 1'b1; wclk(Q);
      s = sda_line; wclk(Q); scl = 1'b0; wclk(Q);
   endtask

   task automatic byte_tx(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic byte_rx(input logic give_ack, output logic [7:0] d);
      logic s;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s);
         d = {d[6:0], s};
      end
      clk_bit(~give_ack, s);
   endtask

   task automatic model_write(input logic [7:0] p0, input int n);
      logic [7:0] p;
      p = p0;
      for (int k = 0; k < n; k++) begin
         if (p < 8'(N)) begin
            if (!m_lock) m_sh[int'(p)] = wbuf[k];
         end else if (p == 8'(N) && wbuf[k][0]) begin
            m_lock = 1'b1;
         end
         p = nxt(p);
      end
      commit_model();
   endtask

   task automatic write_bytes(input logic [7:0] p, input int n, input string req);
      logic a;
      bus_start();
      byte_tx({DEV, 1'b0}, a); chk({req, " R2 address ack"}, a, 1);
      byte_tx(p, a);           chk({req, " R3 pointer ack"}, a, 1);
      for (int k = 0; k < n; k++) begin
         byte_tx(wbuf[k], a);  chk({req, " R3 data ack"}, a, 1);
      end
      bus_stop();
      wclk(10);
      model_write(p, n);
   endtask

   task automatic read_check(input logic [7:0] p, input int n, input string req);
      logic a;
      logic [7:0] pp;
      bus_start();
      byte_tx({DEV, 1'b0}, a); chk({req, " R2 address ack"}, a, 1);
      byte_tx(p, a);           chk({req, " R3 pointer ack"}, a, 1);
      bus_start();
      byte_tx({DEV, 1'b1}, a); chk({req, " R9 repeated start read ack"}, a, 1);
      for (int k = 0; k < n; k++) byte_rx(k != n - 1, rbuf[k]);
      bus_stop();
      wclk(10);
      pp = p;
      for (int k = 0; k < n; k++) begin
         chk({req, " R4 read data"}, rbuf[k], exp_rd(pp));
         pp = nxt(pp);
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic a, s;
      logic [7:0] d, p;
      int n;
      void'($urandom(32'h2F1A));
      for (int i = 0; i < N; i++) begin m_sh[i] = '0; m_bk[i] = '0; end

      // R1: reset state
      wclk(10);
      chk("R1 released in reset", sda_oe, 0);
      rst_n = 1'b1;
      wclk(10);
      chk("R1 released after reset", sda_oe, 0);
      read_check(8'd0, N + 1, "R1 reset contents");

      // R3: directed write, then read back
      wbuf[0] = 8'h81; wbuf[1] = 8'h7E; wbuf[2] = 8'h00;
      write_bytes(8'd0, 3, "R3 burst");
      read_check(8'd0, 3, "R3 readback");

      // R2: foreign address is ignored until next START
      bus_start();
      byte_tx({DEV ^ 7'h01, 1'b0}, a); chk("R2 foreign address no ack", a, 0);
      byte_tx(8'h01, a);               chk("R2 foreign pointer no ack", a, 0);
      byte_tx(8'hEE, a);               chk("R2 foreign data no ack", a, 0);
      bus_stop();
      wclk(10);
      read_check(8'd0, 3, "R2 foreign write ignored");

      // random bursts
      for (int it = 0; it < 16; it++) begin
         p = 8'($urandom_range(N - 1));
         n = int'($urandom_range(4, 1));
         for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
         write_bytes(p, n, "R3 random");
         if (it % 2 == 0) read_check(8'($urandom_range(N - 1)), int'($urandom_range(6, 1)), "R4 random");
      end

      // R9: repeated START between two writes; R10: START releases
      bus_start();
      byte_tx({DEV, 1'b0}, a); chk("R9 first address ack", a, 1);
      byte_tx(8'd5, a);        chk("R9 pointer ack", a, 1);
      byte_tx(8'hC3, a);       chk("R9 data ack", a, 1);
      bus_start();
      chk("R10 released after START", sda_oe, 0);
      byte_tx({DEV, 1'b0}, a); chk("R9 second address ack", a, 1);
      byte_tx(8'd6, a);        chk("R9 second pointer ack", a, 1);
      byte_tx(8'h3C, a);       chk("R9 second data ack", a, 1);
      bus_stop();
      wclk(10);
      wbuf[0] = 8'hC3; model_write(8'd5, 1);
      wbuf[0] = 8'h3C; model_write(8'd6, 1);
      read_check(8'd5, 2, "R9 both writes landed");

      // R5: master NACK ends read, slave releases
      bus_start();
      byte_tx({DEV, 1'b0}, a);
      byte_tx(8'd5, a);
      bus_start();
      byte_tx({DEV, 1'b1}, a);
      byte_rx(1'b0, d);
      chk("R5 byte before nack", d, exp_rd(8'd5));
      clk_bit(1'b1, s); chk("R5 line released after nack", s, 1);
      clk_bit(1'b1, s); chk("R5 line still released", s, 1);
      chk("R5 enable low after nack", sda_oe, 0);
      bus_stop();
      wclk(10);

      // R6: deferred commit
      evt = 1'b1; wclk(10);
      wbuf[0] = ~exp_rd(8'd2);
      write_bytes(8'd2, 1, "R6 write under event");
      read_check(8'd2, 1, "R6 held while event active");
      evt = 1'b0; wclk(10);
      commit_model();
      read_check(8'd2, 1, "R6 visible after event drops");

      // R8: out of range pointer
      wbuf[0] = 8'h77; wbuf[1] = 8'h3C;
      write_bytes(8'h40, 2, "R8 out of range");
      read_check(8'h40, 2, "R8 reads FF then location 0");

      // R4: write wrap from the lock location
      wbuf[0] = 8'h00; wbuf[1] = 8'hA5;
      write_bytes(8'd10, 2, "R4 write wrap");
      read_check(8'd9, 3, "R4 read wrap");

      // R7: lock
      wbuf[0] = 8'h01;
      write_bytes(8'd10, 1, "R7 set lock");
      read_check(8'd10, 1, "R7 lock reads 1");
      wbuf[0] = ~exp_rd(8'd3); wbuf[1] = ~exp_rd(8'd4);
      write_bytes(8'd3, 2, "R7 locked write acked");
      read_check(8'd3, 2, "R7 locked write ignored");
      wbuf[0] = 8'h00;
      write_bytes(8'd10, 1, "R7 clear attempt");
      read_check(8'd10, 1, "R7 lock sticky");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule